// File: doc/BRIEF.md
# Dual-Bank Divider Clock Crosspoint

This block builds two output clock waveforms from three sources: a reference level and two divider banks. Each bank counts its own input clock and derives a programmable divide-by-N waveform together with fixed taps. Bank one provides divide-by-2 and divide-by-3. Bank two provides divide-by-2 and divide-by-4. Each output picks one of seven sources with its own 3-bit code and has its own enable.

The whole block runs in one system clock domain. Each bank's input clock arrives as a tick strobe, one pulse per source clock cycle, so every derived waveform is a registered level. The fixed taps are decoded from the same counter as the programmable divider. Whenever the usage rules on N hold, their rising edges fall on the rising edges of the divide-by-N output.

Configuration is loaded through a small write port. It holds the two N values, a packed select byte and an enable byte. Loading an N value restarts that bank one cycle later. Loading the select byte restarts both banks. This puts every bank back into a known phase.

Top module: `dual_bank_clk_xbar`

## Requirements
- R1: After synchronous reset both outputs and the error flag are 0, both N values are 8, both select codes are 000 (reference) and both enables are 0.
- R2: A write to address 0 sets N for bank 1 and a write to address 1 sets N for bank 2. Write data below 4 is stored as 4 and write data above 127 is stored as 127.
- R3: The error flag rises on any N write outside 4..127 and stays high until reset, even after later legal writes.
- R4: Source codes are 000 reference, 001 bank-1 /N, 010 bank-1 /2, 011 bank-1 /3, 100 bank-2 /N, 101 bank-2 /2 and 110 bank-2 /4. Each output is registered, so it shows its source one system clock later.
- R5: An output whose select code is 111 stays at 0.
- R6: Address 3 holds the enables, with bit 0 for output 1 and bit 1 for output 2. An output whose enable is 0 stays at 0.
- R7: Address 2 holds the select codes, with bits 7:5 for output 1 and bits 3:1 for output 2. Bits 4 and 0 have no effect.
- R8: The divide-by-N output is high for floor(N/2) bank ticks and low for ceil(N/2) bank ticks.
- R9: The /2 taps are high for 1 tick and low for 1 tick. The /3 tap is high for 1 tick and low for 2. The /4 tap is high for 2 and low for 2. Under the usage rules (bank-1 /3 with N=6, /2 with N a multiple of 4, /4 with N a multiple of 8), each tap rises in the same cycle as its bank's divide-by-N output.
- R10: Writing a bank's N, or writing the select byte, clears the affected counters on the following cycle. The divide-by-N output then starts with its high phase. Its output rises in the second cycle after the write, and when ticks are continuous it stays high for floor(N/2) cycles.
- R11: Bank counters advance only in cycles where the bank's tick strobe is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| refClk | input | 1 | Reference source level |
| bank1Tick | input | 1 | One pulse per bank-1 input clock cycle |
| bank2Tick | input | 1 | One pulse per bank-2 input clock cycle |
| wrEn | input | 1 | Configuration write strobe |
| wrAddr | input | 2 | Configuration address (0 N1, 1 N2, 2 select, 3 enable) |
| wrData | input | 8 | Configuration write data |
| clkOut1 | output | 1 | Output 1 waveform |
| clkOut2 | output | 1 | Output 2 waveform |
| errFlag | output | 1 | Sticky out-of-range N indication |

## Verification
The bench builds the block with its default parameters. These are a 7-bit N ranging from 4 to 127, a default N of 8 and 8-bit write data. With these values both clamp limits can be provoked from the 8-bit write port. Even the longest period, 127, fits within one 512-sample trace. Using N values of 6, 7, 16 and 10 covers every fixed-tap alignment rule and both duty-cycle cases of the divider.

// File: rtl/clk_xbar_pkg.sv
package clk_xbar_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_N1  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_N2  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_SEL = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_OE  = 2'd3;
  localparam int NUM_BANKS = 2;
  localparam int NUM_OUTS  = 2;
  localparam int SEL_W     = 3;

  typedef enum logic [SEL_W-1:0] {
    SRC_REF   = 3'd0,
    SRC_B1_N  = 3'd1,
    SRC_B1_D2 = 3'd2,
    SRC_B1_D3 = 3'd3,
    SRC_B2_N  = 3'd4,
    SRC_B2_D2 = 3'd5,
    SRC_B2_D4 = 3'd6,
    SRC_RSVD  = 3'd7
  } srcSel_t;

  typedef struct packed {
    logic [NUM_BANKS-1:0] restart;
  } ctrlStrobes_t;
endpackage

// File: rtl/clk_xbar_ctrl.sv
module clk_xbar_ctrl
  import clk_xbar_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int N_W    = 7,
  parameter int N_MIN  = 4,
  parameter int N_MAX  = 127,
  parameter int N_DEF  = 8
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                wrEn,
  input  logic [ADDR_W-1:0]                   wrAddr,
  input  logic [DATA_W-1:0]                   wrData,
  output logic [NUM_BANKS-1:0][N_W-1:0]       divN,
  output logic [NUM_OUTS-1:0][SEL_W-1:0]      outSel,
  output logic [NUM_OUTS-1:0]                 outEn,
  output logic                                errFlag,
  output ctrlStrobes_t                        strobes
);
  localparam logic [DATA_W-1:0] MIN_D = DATA_W'(N_MIN);
  localparam logic [DATA_W-1:0] MAX_D = DATA_W'(N_MAX);

  logic tooLow, tooHigh;
  logic [N_W-1:0] clampedN;

  always_comb begin
    tooLow  = wrData < MIN_D;
    tooHigh = wrData > MAX_D;
    if (tooLow)       clampedN = N_W'(N_MIN);
    else if (tooHigh) clampedN = N_W'(N_MAX);
    else              clampedN = wrData[N_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      divN    <= {NUM_BANKS{N_W'(N_DEF)}};
      outSel  <= '0;
      outEn   <= '0;
      errFlag <= 1'b0;
      strobes <= '0;
    end else begin
      strobes.restart <= '0;
      if (wrEn) begin
        for (int b = 0; b < NUM_BANKS; b++) begin
          if (wrAddr == ADDR_W'(b)) begin
            divN[b]            <= clampedN;
            strobes.restart[b] <= 1'b1;
            if (tooLow || tooHigh) errFlag <= 1'b1;
          end
        end
        if (wrAddr == ADDR_SEL) begin
          outSel[0]       <= wrData[7:5];
          outSel[1]       <= wrData[3:1];
          strobes.restart <= '1;
        end
        if (wrAddr == ADDR_OE) outEn <= wrData[NUM_OUTS-1:0];
      end
    end
  end
endmodule

// File: rtl/clk_xbar_dp.sv
module clk_xbar_dp
  import clk_xbar_pkg::*;
#(
  parameter int N_W = 7
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           refClk,
  input  logic [NUM_BANKS-1:0]           bankTick,
  input  logic [NUM_BANKS-1:0][N_W-1:0]  divN,
  input  logic [NUM_OUTS-1:0][SEL_W-1:0] outSel,
  input  logic [NUM_OUTS-1:0]            outEn,
  input  ctrlStrobes_t                   strobes,
  output logic [NUM_OUTS-1:0]            clkOut
);
  logic [NUM_BANKS-1:0][N_W-1:0] bankCnt;
  logic [NUM_BANKS-1:0] wrap, progTap, halfTap, fixedTap;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : gBank
    assign wrap[b]    = bankCnt[b] == divN[b] - N_W'(1);
    assign progTap[b] = bankCnt[b] < (divN[b] >> 1);
    assign halfTap[b] = ~bankCnt[b][0];

    always_ff @(posedge clk) begin
      if (rst || strobes.restart[b])  bankCnt[b] <= '0;
      else if (bankTick[b])           bankCnt[b] <= wrap[b] ? '0 : bankCnt[b] + N_W'(1);
    end

    if (b == 0) begin : gDiv3
      logic [1:0] mod3;
      always_ff @(posedge clk) begin
        if (rst || strobes.restart[b])  mod3 <= '0;
        else if (bankTick[b])           mod3 <= (wrap[b] || mod3 == 2'd2) ? 2'd0 : mod3 + 2'd1;
      end
      assign fixedTap[b] = mod3 == 2'd0;
    end else begin : gDiv4
      assign fixedTap[b] = bankCnt[b][1:0] < 2'd2;
    end
  end

  for (genvar o = 0; o < NUM_OUTS; o++) begin : gOut
    logic picked;
    always_comb begin
      case (srcSel_t'(outSel[o]))
        SRC_REF:   picked = refClk;
        SRC_B1_N:  picked = progTap[0];
        SRC_B1_D2: picked = halfTap[0];
        SRC_B1_D3: picked = fixedTap[0];
        SRC_B2_N:  picked = progTap[1];
        SRC_B2_D2: picked = halfTap[1];
        SRC_B2_D4: picked = fixedTap[1];
        default:   picked = 1'b0;
      endcase
    end
    always_ff @(posedge clk) begin
      if (rst) clkOut[o] <= 1'b0;
      else     clkOut[o] <= outEn[o] & picked;
    end
  end
endmodule

// File: rtl/dual_bank_clk_xbar.sv
module dual_bank_clk_xbar
  import clk_xbar_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int N_W    = 7,
  parameter int N_MIN  = 4,
  parameter int N_MAX  = 127,
  parameter int N_DEF  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              refClk,
  input  logic              bank1Tick,
  input  logic              bank2Tick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              clkOut1,
  output logic              clkOut2,
  output logic              errFlag
);
  logic [NUM_BANKS-1:0][N_W-1:0]  divN;
  logic [NUM_OUTS-1:0][SEL_W-1:0] outSel;
  logic [NUM_OUTS-1:0]            outEn;
  logic [NUM_OUTS-1:0]            clkOut;
  ctrlStrobes_t                   strobes;

  clk_xbar_ctrl #(.DATA_W(DATA_W), .N_W(N_W), .N_MIN(N_MIN), .N_MAX(N_MAX), .N_DEF(N_DEF)) uCtrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .divN(divN), .outSel(outSel), .outEn(outEn), .errFlag(errFlag), .strobes(strobes)
  );

  clk_xbar_dp #(.N_W(N_W)) uDp (
    .clk(clk), .rst(rst), .refClk(refClk), .bankTick({bank2Tick, bank1Tick}),
    .divN(divN), .outSel(outSel), .outEn(outEn), .strobes(strobes), .clkOut(clkOut)
  );

  assign clkOut1 = clkOut[0];
  assign clkOut2 = clkOut[1];
endmodule

// File: rtl/clk_xbar_checker.sv
module clk_xbar_checker
  import clk_xbar_pkg::*;
#(
  parameter int N_W   = 7,
  parameter int N_MIN = 4,
  parameter int N_MAX = 127
) (
  input logic                           clk,
  input logic                           rst,
  input logic                           wrEn,
  input logic [ADDR_W-1:0]              wrAddr,
  input logic [NUM_BANKS-1:0][N_W-1:0]  divN,
  input logic [NUM_BANKS-1:0][N_W-1:0]  bankCnt,
  input logic [NUM_OUTS-1:0][SEL_W-1:0] outSel,
  input logic [NUM_OUTS-1:0]            outEn,
  input logic                           clkOut1,
  input logic                           clkOut2,
  input logic                           errFlag
);
  assert_n_in_range_R2: assert property (@(posedge clk) disable iff (rst)
    divN[0] >= N_W'(N_MIN) && divN[0] <= N_W'(N_MAX) && divN[1] >= N_W'(N_MIN) && divN[1] <= N_W'(N_MAX));

  assert_err_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    $past(errFlag) |-> errFlag);

  assert_reserved_low_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(outSel[0]) == SRC_RSVD) |-> !clkOut1);

  assert_reserved2_low_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(outSel[1]) == SRC_RSVD) |-> !clkOut2);

  assert_disabled_low_R6: assert property (@(posedge clk) disable iff (rst)
    !$past(outEn[0]) |-> !clkOut1);

  assert_disabled2_low_R6: assert property (@(posedge clk) disable iff (rst)
    !$past(outEn[1]) |-> !clkOut2);

  assert_restart_b1_R10: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrAddr == ADDR_N1) |-> ##2 (bankCnt[0] == '0));

  assert_restart_b2_R10: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrAddr == ADDR_N2) |-> ##2 (bankCnt[1] == '0));
endmodule

bind dual_bank_clk_xbar clk_xbar_checker #(.N_W(N_W), .N_MIN(N_MIN), .N_MAX(N_MAX)) uChk (
  .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .divN(divN), .bankCnt(uDp.bankCnt),
  .outSel(outSel), .outEn(outEn), .clkOut1(clkOut1), .clkOut2(clkOut2), .errFlag(errFlag)
);

// File: tb/dual_bank_clk_xbar_test.sv
module dual_bank_clk_xbar_test;
  localparam int TL = 512;
  logic clk = 1'b0, rst = 1'b1, refClk = 1'b0;
  logic bank1Tick = 1'b1, bank2Tick = 1'b1, wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic clkOut1, clkOut2, errFlag;
  logic [TL-1:0] trace1, trace2;
  int nTests = 0, nFail = 0;
  bit finished = 0;

  dual_bank_clk_xbar uut (
    .clk(clk), .rst(rst), .refClk(refClk), .bank1Tick(bank1Tick), .bank2Tick(bank2Tick),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .clkOut1(clkOut1), .clkOut2(clkOut2), .errFlag(errFlag)
  );

  always #4 clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1 wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk); #1 wrEn = 1'b0;
  endtask

  task automatic capture(input bit halfTick);
    for (int i = 0; i < TL; i++) begin
      @(posedge clk); #1 if (halfTick) bank1Tick = ~bank1Tick;
      @(negedge clk);
      trace1[i] = clkOut1;
      trace2[i] = clkOut2;
    end
    bank1Tick = 1'b1;
  endtask

  function automatic int firstRise(input logic [TL-1:0] tr);
    for (int i = 1; i < TL; i++) if (tr[i] && !tr[i-1]) return i;
    return -1;
  endfunction

  function automatic int runLen(input logic [TL-1:0] tr, input int start, input logic val);
    int n = 0;
    for (int i = start; i < TL; i++) begin
      if (tr[i] !== val) break;
      n++;
    end
    return n;
  endfunction

  task automatic checkWave(input string req, input logic [TL-1:0] tr, input int expHi, input int expLo);
    int r = firstRise(tr);
    int h;
    check(req, "rising edge found", int'(r >= 1), 1);
    if (r < 1) return;
    h = runLen(tr, r, 1'b1);
    check(req, "high run", h, expHi);
    check(req, "low run", runLen(tr, r + h, 1'b0), expLo);
  endtask

  task automatic checkAligned(input string req);
    int r = firstRise(trace1);
    if (r < 1) r = 1;
    check(req, "tap rises with N output", int'(trace2[r] && !trace2[r-1]), 1);
  endtask

  task automatic testReset();
    check("R1", "clkOut1 after reset", int'(clkOut1), 0);
    check("R1", "clkOut2 after reset", int'(clkOut2), 0);
    check("R1", "errFlag after reset", int'(errFlag), 0);
    writeReg(2'd3, 8'h03);
    @(posedge clk); #1 refClk = 1'b1;
    @(negedge clk);
    check("R4", "reference not yet visible", int'(clkOut1), 0);
    @(negedge clk);
    check("R4", "reference out1 after one clock", int'(clkOut1), 1);
    check("R1", "default select is reference on out2", int'(clkOut2), 1);
    refClk = 1'b0;
    writeReg(2'd2, 8'h28);
    capture(1'b0);
    checkWave("R1", trace1, 4, 4);
  endtask

  task automatic testDiv3();
    writeReg(2'd0, 8'd6);
    writeReg(2'd2, 8'h26);
    capture(1'b0);
    checkWave("R8", trace1, 3, 3);
    checkWave("R9", trace2, 1, 2);
    checkAligned("R9");
  endtask

  task automatic testOddAndIgnored();
    writeReg(2'd0, 8'd7);
    writeReg(2'd2, 8'h37);
    capture(1'b0);
    checkWave("R8", trace1, 3, 4);
    checkWave("R7", trace2, 1, 2);
  endtask

  task automatic testBank2();
    writeReg(2'd1, 8'd16);
    writeReg(2'd2, 8'h8C);
    capture(1'b0);
    checkWave("R9", trace1, 8, 8);
    checkWave("R9", trace2, 2, 2);
    checkAligned("R9");
    writeReg(2'd2, 8'h8A);
    capture(1'b0);
    checkWave("R9", trace2, 1, 1);
    checkAligned("R9");
    writeReg(2'd0, 8'd8);
    writeReg(2'd2, 8'h24);
    capture(1'b0);
    checkWave("R9", trace2, 1, 1);
    checkAligned("R9");
  endtask

  task automatic testClamp();
    writeReg(2'd0, 8'd2);
    writeReg(2'd2, 8'h20);
    capture(1'b0);
    checkWave("R2", trace1, 2, 2);
    check("R3", "errFlag after low write", int'(errFlag), 1);
    writeReg(2'd0, 8'd200);
    capture(1'b0);
    checkWave("R2", trace1, 63, 64);
    writeReg(2'd0, 8'd8);
    @(negedge clk);
    check("R3", "errFlag stays after legal write", int'(errFlag), 1);
  endtask

  task automatic testReservedAndEnable();
    writeReg(2'd0, 8'd4);
    writeReg(2'd2, 8'hE2);
    capture(1'b0);
    check("R5", "reserved out1 stays low", int'(trace1 == '0), 1);
    checkWave("R5", trace2, 2, 2);
    writeReg(2'd2, 8'h22);
    writeReg(2'd3, 8'h02);
    capture(1'b0);
    check("R6", "disabled out1 stays low", int'(trace1 == '0), 1);
    checkWave("R6", trace2, 2, 2);
    writeReg(2'd3, 8'h03);
  endtask

  task automatic testTick();
    writeReg(2'd0, 8'd4);
    writeReg(2'd2, 8'h20);
    capture(1'b1);
    checkWave("R11", trace1, 4, 4);
  endtask

  task automatic testRestart();
    writeReg(2'd2, 8'h20);
    writeReg(2'd0, 8'd10);
    capture(1'b0);
    check("R10", "high for 5 from 2nd cycle after write", int'(trace1[5:1] == 5'b11111), 1);
    check("R10", "then low for 5", int'(trace1[10:6] == 5'b00000), 1);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    testReset();
    testDiv3();
    testOddAndIgnored();
    testBank2();
    testClamp();
    testReservedAndEnable();
    testTick();
    testRestart();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      finished = 1;
      nTests++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule